// File: doc/BRIEF.md
# Dual-Mode Double-Buffered DAC Input Interface

This block is the digital front end of a 16-bit digital-to-analog converter. A host delivers a code word in one of two ways: as a bit stream clocked by rising edges of a chip-select strobe, or as two 8-bit bytes steered by high-half and low-half enables. The word collects in a first-rank holding register. A level-sensitive load input copies it into a second-rank register, which drives the converter code. Because the code only changes on load, several converters on one bus can be written one after another and then updated together.

In serial mode, the two lowest data lines take on new roles. Line 0 carries the serial data and line 1 selects the bit order. Each bit pushed out of the holding register appears on a serial output, so devices can be chained. A clear input forces the converter code to a zero level without disturbing the holding register. The low-half enable decides whether that zero level is unipolar or bipolar. All control inputs are sampled in one system clock domain. The strobe, load and clear inputs pass through synchronizers. Clear reaches the output code at once and is released through its synchronizer.

Top module: `dual_mode_dac_if`

## Requirements
- R1: After a synchronous active-low reset, the holding register and the converter code are 0x0000 and the serial output is 0.
- R2: With `byte_mode` low and `bus_d[1]` = 1 at a strobe rising edge, the holding register shifts toward its top bit and `bus_d[0]` enters bit 0. After 16 strobes, the first bit sent is in bit 15.
- R3: With `byte_mode` low and `bus_d[1]` = 0, the holding register shifts toward bit 0 and `bus_d[0]` enters bit 15. After 16 strobes, the first bit sent is in bit 0.
- R4: In serial mode, `hi_en` and `lo_en` have no effect on the holding register.
- R5: Each serial strobe puts the bit leaving the holding register on `shift_out`: bit 15 in the top-first order, bit 0 in the bottom-first order. On the 17th strobe, the first bit of a word reaches `shift_out`.
- R6: With `byte_mode` high, a strobe rising edge writes `bus_d` into bits 15..8 when `hi_en` is high, and into bits 7..0 when `lo_en` is high. The two halves may be written in either order.
- R7: When both enables are high at a byte write, the same byte goes into both halves.
- R8: Writes happen only on a strobe rising edge. While the strobe stays high or low, changes on the bus do not alter the holding register.
- R9: While `load` is high, the converter code follows the holding register. While `load` is low, the code holds its value.
- R10: While `clr` is high, `dac_code` is forced at once to 0x0000 if `lo_en` is low, or to 0x8000 if `lo_en` is high. After release, the second rank keeps that value.
- R11: Clear does not change the holding register, so a later load restores the previous word.
- R12: Clear takes priority over load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_strobe | input | 1 | Chip-select strobe; its rising edge writes or shifts |
| byte_mode | input | 1 | 1 = byte mode, 0 = serial mode |
| hi_en | input | 1 | Upper-half enable (byte mode) |
| lo_en | input | 1 | Lower-half enable (byte mode); clear-level select (1 = 0x8000) |
| bus_d | input | 8 | Data bus; in serial mode bit 0 = data and bit 1 = order (1 = top first) |
| load | input | 1 | Level-sensitive transfer to the second rank |
| clr | input | 1 | Clears the second rank to the level chosen by lo_en |
| shift_out | output | 1 | Bit pushed out of the holding register, for chaining |
| dac_code | output | 16 | Converter code from the second rank |

## Verification
The assertions check, on every cycle, these cycle-level rules:
- The holding register and the serial output stay still when there is no strobe edge.
- Each serial shift takes in the sampled data bit and pushes out the correct end bit.
- Byte writes touch only the enabled half.
- The second rank holds, follows or clears according to load and clear.
- The holding register survives a clear.

Some behaviours span many cycles and only the bench's scenarios can show them:
- whole words assembled in each bit order or byte order;
- the 17th-strobe handoff on the serial output;
- the enables being ignored in serial mode;
- restoring a word after clear;
- the immediate clear levels seen at the port.

// File: rtl/dacif_pkg.sv
// Shared types for the dual-mode DAC input interface.
package dacif_pkg;

    // Serial bit order, carried on bus line 1 in serial mode.
    typedef enum logic {
        ORDER_BOTTOM_FIRST = 1'b0,
        ORDER_TOP_FIRST    = 1'b1
    } shift_order_e;

    // Control inputs that cross into the system clock domain.
    typedef struct packed {
        logic strobe;
        logic load;
        logic clr;
    } ctrl_t;

endpackage

// File: rtl/dacif_sync.sv
// Multi-stage flip-flop synchronizer for a bundle of asynchronous inputs.
// Assumes STAGES >= 2 and that each bit is an independent level signal.
module dacif_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift the raw inputs through the synchronizing chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/dacif_first_rank.sv
// First-rank holding register. On each write edge it either shifts one
// serial bit (in either order) or writes bytes into the enabled halves.
// Assumes the mode, enable and bus inputs are stable around the write edge.
module dacif_first_rank
    import dacif_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_edge,
    input  logic                byte_mode,
    input  logic                hi_en,
    input  logic                lo_en,
    input  logic [WORD_W/2-1:0] bus_d,
    output logic [WORD_W-1:0]   word_q,
    output logic                shift_out
);
    localparam int BYTE_W = WORD_W / 2;

    shift_order_e order;
    logic         ser_bit;

    assign order   = shift_order_e'(bus_d[1]);
    assign ser_bit = bus_d[0];

    // Update the holding word and the chaining output on a write edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q    <= '0;
            shift_out <= 1'b0;
        end else if (wr_edge) begin
            if (!byte_mode) begin
                if (order == ORDER_TOP_FIRST) begin
                    word_q    <= {word_q[WORD_W-2:0], ser_bit};
                    shift_out <= word_q[WORD_W-1];
                end else begin
                    word_q    <= {ser_bit, word_q[WORD_W-1:1]};
                    shift_out <= word_q[0];
                end
            end else begin
                if (hi_en) word_q[WORD_W-1:BYTE_W] <= bus_d;
                if (lo_en) word_q[BYTE_W-1:0]      <= bus_d;
            end
        end
    end

    // R8: no edge, no change to the holding word or the chain output.
    assert_no_edge_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_edge |=> $stable(word_q) && $stable(shift_out));

    // R2 / R5: a top-first shift takes the bit at bit 0 and pushes out bit 15.
    assert_top_first_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_edge && !byte_mode && bus_d[1]
        |=> word_q[0] == $past(bus_d[0]) && shift_out == $past(word_q[WORD_W-1]));

    // R3 / R5: a bottom-first shift takes the bit at the top and pushes out bit 0.
    assert_bottom_first_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_edge && !byte_mode && !bus_d[1]
        |=> word_q[WORD_W-1] == $past(bus_d[0]) && shift_out == $past(word_q[0]));

    // R6: a byte write without the upper enable leaves the upper half alone.
    assert_upper_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_edge && byte_mode && !hi_en |=> $stable(word_q[WORD_W-1:BYTE_W]));
endmodule

// File: rtl/dacif_second_rank.sv
// Second-rank DAC register. It follows the first rank while load is high.
// The clear path forces the output combinationally from the raw pin and
// holds the register at the zero level until the synchronized clear falls.
// Assumes lo_en is held steady while clear is active.
module dacif_second_rank #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_lvl,
    input  logic              clr_raw,
    input  logic              clr_sync,
    input  logic              zero_sel,
    input  logic [WORD_W-1:0] first_word,
    output logic [WORD_W-1:0] dac_code
);
    logic              clr_active;
    logic [WORD_W-1:0] zero_code;
    logic [WORD_W-1:0] held_q;

    assign clr_active = clr_raw | clr_sync;
    assign zero_code  = {zero_sel, {(WORD_W-1){1'b0}}};

    // Clear beats load; load copies the first rank each cycle it is high.
    always_ff @(posedge clk) begin
        if (!rst_n)          held_q <= '0;
        else if (clr_active) held_q <= zero_code;
        else if (load_lvl)   held_q <= first_word;
    end

    assign dac_code = clr_active ? zero_code : held_q;

    // R9: with neither load nor clear, the register holds.
    assert_hold_without_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_active && !load_lvl |=> $stable(held_q));

    // R9: load copies the first-rank word.
    assert_load_copies_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_active && load_lvl |=> held_q == $past(first_word));

    // R12: during clear, load cannot put data into the low bits.
    assert_clear_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        clr_active && load_lvl |=> held_q[WORD_W-2:0] == '0);
endmodule

// File: rtl/dual_mode_dac_if.sv
// Top level of the dual-mode double-buffered DAC input interface.
// Synchronizes strobe, load and clear, detects strobe rising edges, and
// joins the first-rank and second-rank registers.
// Assumes the data bus, mode and enables are stable for the synchronizer
// delay plus one cycle after a strobe rising edge.
module dual_mode_dac_if
    import dacif_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_strobe,
    input  logic                byte_mode,
    input  logic                hi_en,
    input  logic                lo_en,
    input  logic [WORD_W/2-1:0] bus_d,
    input  logic                load,
    input  logic                clr,
    output logic                shift_out,
    output logic [WORD_W-1:0]   dac_code
);
    ctrl_t             ctl_raw;
    ctrl_t             ctl_s;
    logic              strobe_prev;
    logic              wr_edge;
    logic [WORD_W-1:0] first_word;

    assign ctl_raw = '{strobe: cs_strobe, load: load, clr: clr};

    dacif_sync #(.WIDTH($bits(ctrl_t)), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ctl_raw),
        .sync_out (ctl_s)
    );

    // Remember the last synchronized strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_prev <= 1'b0;
        else        strobe_prev <= ctl_s.strobe;
    end

    assign wr_edge = ctl_s.strobe & ~strobe_prev;

    dacif_first_rank #(.WORD_W(WORD_W)) i_first (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_edge   (wr_edge),
        .byte_mode (byte_mode),
        .hi_en     (hi_en),
        .lo_en     (lo_en),
        .bus_d     (bus_d),
        .word_q    (first_word),
        .shift_out (shift_out)
    );

    dacif_second_rank #(.WORD_W(WORD_W)) i_second (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_lvl   (ctl_s.load),
        .clr_raw    (clr),
        .clr_sync   (ctl_s.clr),
        .zero_sel   (lo_en),
        .first_word (first_word),
        .dac_code   (dac_code)
    );

    // R11: clear does not disturb the first rank.
    assert_first_kept_on_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr || ctl_s.clr) && !wr_edge |=> $stable(first_word));

    // R8: a strobe level held high yields at most one write edge.
    assert_single_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_edge |=> !wr_edge);
endmodule

// File: tb/test_dual_mode_dac_if.sv
`timescale 1ns/1ps
module test_dual_mode_dac_if;
    typedef struct {
        int          req;
        bit          is_sout;
        logic [15:0] val;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_strobe = 1'b0;
    logic        byte_mode = 1'b1;
    logic        hi_en = 1'b0;
    logic        lo_en = 1'b0;
    logic [7:0]  bus_d = 8'h00;
    logic        load = 1'b0;
    logic        clr = 1'b0;
    logic        shift_out;
    logic [15:0] dac_code;

    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;
    sb_item_t    sb_q[$];
    logic [15:0] m_fr = 16'h0000;
    logic        m_sout = 1'b0;

    always #4 clk = ~clk;

    dual_mode_dac_if i_dual_mode_dac_if (
        .clk(clk), .rst_n(rst_n), .cs_strobe(cs_strobe), .byte_mode(byte_mode),
        .hi_en(hi_en), .lo_en(lo_en), .bus_d(bus_d), .load(load), .clr(clr),
        .shift_out(shift_out), .dac_code(dac_code)
    );

    // Monitor: pop expected items and compare them at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() != 0) begin
                sb_item_t it;
                logic [15:0] act;
                it  = sb_q.pop_front();
                act = it.is_sout ? {15'h0, shift_out} : dac_code;
                checks++;
                if (act !== it.val) begin
                    failures++;
                    $display("FAIL R%0d: %s actual=0x%04h expected=0x%04h",
                             it.req, it.is_sout ? "shift_out" : "dac_code", act, it.val);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_val(input int req, input bit is_sout, input logic [15:0] v);
        sb_q.push_back('{req: req, is_sout: is_sout, val: v});
        wait (sb_q.size() == 0);
        tick(1);
    endtask

    task automatic strobe();
        cs_strobe = 1'b1; tick(4);
        cs_strobe = 1'b0; tick(4);
    endtask

    task automatic load_pulse();
        load = 1'b1; tick(6);
        load = 1'b0; tick(4);
    endtask

    task automatic byte_wr(input bit hi, input bit lo, input logic [7:0] v);
        byte_mode = 1'b1; hi_en = hi; lo_en = lo; bus_d = v;
        tick(1);
        strobe();
        if (hi) m_fr[15:8] = v;
        if (lo) m_fr[7:0]  = v;
        hi_en = 1'b0; lo_en = 1'b0;
    endtask

    // Shift a bit; the enables toggle to show they are ignored (R4).
    task automatic ser_bit(input bit b, input bit top_first, input int idx);
        byte_mode = 1'b0; bus_d = {6'b0, top_first, b};
        hi_en = 1'b1; lo_en = idx[0];
        tick(1);
        strobe();
        if (top_first) begin m_sout = m_fr[15]; m_fr = {m_fr[14:0], b}; end
        else           begin m_sout = m_fr[0];  m_fr = {b, m_fr[15:1]}; end
    endtask

    task automatic ser_word(input logic [15:0] w, input bit top_first);
        for (int i = 0; i < 16; i++)
            ser_bit(top_first ? w[15-i] : w[i], top_first, i);
        hi_en = 1'b0; lo_en = 1'b0; byte_mode = 1'b1;
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Driver: stimulus plus expected values from the requirements.
    initial begin
        tick(3);
        expect_val(1, 1'b0, 16'h0000);                 // R1 code
        expect_val(1, 1'b1, 16'h0000);                 // R1 chain out
        rst_n = 1'b1; tick(2);

        byte_wr(1'b0, 1'b1, 8'h34); byte_wr(1'b1, 1'b0, 8'h12);
        load_pulse();
        expect_val(6, 1'b0, 16'h1234);                 // R6 low then high

        byte_wr(1'b1, 1'b0, 8'hAB); byte_wr(1'b0, 1'b1, 8'hCD);
        load_pulse();
        expect_val(6, 1'b0, 16'hABCD);                 // R6 high then low

        byte_wr(1'b0, 1'b1, 8'h77); tick(8);
        expect_val(9, 1'b0, 16'hABCD);                 // R9 no load, no change

        // R8: bus changes while the strobe stays high.
        byte_mode = 1'b1; lo_en = 1'b1; bus_d = 8'h11; tick(1);
        cs_strobe = 1'b1; tick(5);
        bus_d = 8'h99; tick(5);
        cs_strobe = 1'b0; tick(5);
        bus_d = 8'h55; tick(5);
        lo_en = 1'b0; m_fr[7:0] = 8'h11;
        load_pulse();
        expect_val(8, 1'b0, 16'hAB11);                 // R8 single write per edge

        byte_wr(1'b1, 1'b1, 8'h5A);
        load_pulse();
        expect_val(7, 1'b0, 16'h5A5A);                 // R7 both halves

        ser_word(16'hC3A5, 1'b1);
        expect_val(5, 1'b1, {15'h0, m_sout});          // R5 last bit pushed out
        load_pulse();
        expect_val(2, 1'b0, 16'hC3A5);                 // R2 top-first word, R4 enables ignored
        expect_val(4, 1'b0, m_fr);                     // R4 matches model despite enables
        ser_bit(1'b0, 1'b1, 0);
        byte_mode = 1'b1; hi_en = 1'b0; lo_en = 1'b0;
        expect_val(5, 1'b1, 16'h0001);                 // R5 17th strobe shows first bit

        ser_word(16'h1E6B, 1'b0);
        load_pulse();
        expect_val(3, 1'b0, 16'h1E6B);                 // R3 bottom-first word

        lo_en = 1'b0; tick(1);
        clr = 1'b1; #1;
        expect_val(10, 1'b0, 16'h0000);                // R10 immediate unipolar zero
        clr = 1'b0; tick(6);
        expect_val(10, 1'b0, 16'h0000);                // R10 held after release

        load_pulse();
        expect_val(11, 1'b0, 16'h1E6B);                // R11 word restored

        lo_en = 1'b1; tick(1);
        clr = 1'b1; #1;
        expect_val(10, 1'b0, 16'h8000);                // R10 immediate bipolar zero
        load = 1'b1; tick(6);
        expect_val(12, 1'b0, 16'h8000);                // R12 clear beats load
        clr = 1'b0; tick(8);
        load = 1'b0; lo_en = 1'b0; tick(4);
        expect_val(11, 1'b0, 16'h1E6B);                // R11 load after clear restores

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule